// File: doc/BRIEF.md
# Single-Mode DMA Transfer Sequencer

This block is the per-request engine of a four-channel, byte-wide DMA controller. The caller chooses one channel and presents that channel's mode byte, the controller's mask bits, the channel's current address and count, its base address and count, and a requested length. The engine decides whether the request may move data and, if so, how many elements move. It reports that number and the channel's updated current address and count. At terminal count it raises per-channel status pulses and, in autoinit mode, hands back the base values for reload.

The elements that are moved are then issued to memory one per clock cycle. Each cycle drives an address, a direction and a strobe. A verify transfer takes the same number of cycles but raises no strobe. The register file that holds the channel state, the data path and arbitration between channels all sit outside this block. While elements are still being issued the engine is busy and ignores new requests.

Top module: `dma_single_engine`

## Requirements
- R1: When the mask bit of the requested channel is 1, the request moves nothing. The result reports zero elements, the write-back enable is low, no status pulse fires and no strobe is issued.
- R2: Mode byte bits [7:6] give the operating mode. Only value 01 (single) transfers. Values 00, 10 and 11 behave as in R1.
- R3: Mode byte bits [3:2] give the transfer type. With 00 (verify) the busy cycles run but no strobe is issued. With 01 each strobe writes memory (write enable 1). With 10 each strobe reads memory (write enable 0). 11 is illegal and behaves as in R1.
- R4: For an accepted transfer the moved count is the smaller of the requested length and the current count. The written-back count is the current count minus the moved count.
- R5: Mode byte bit 5 selects the address direction: 0 increments and 1 decrements. The written-back address is the current address plus or minus the moved count, modulo 2^AW. The element size is one byte.
- R6: The moved elements are issued on consecutive cycles, starting with the cycle after acceptance. Their addresses are the current address, then one step further per element in the selected direction. Busy is high exactly for those cycles.
- R7: When an accepted transfer leaves the count at zero, the terminal-count pulse and the request-clear pulse are both raised for the requested channel only. This also applies when the count was already zero. Both pulses come in the same cycle as done.
- R8: With mode byte bit 4 (autoinit) set, reaching terminal count makes the write-back carry the base address and base count instead of the updated values.
- R9: Done pulses for one cycle, and moved count and write-back are valid, one cycle after a request is accepted. A request is accepted only while busy is low. Requests during busy are ignored.
- R10: After reset, done, busy, strobe, write enable, write-back enable and the status pulses are all low, and the moved count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| chan_i | input | CHW | Requested channel |
| len_i | input | CW | Requested element count |
| mode_i | input | 8 | Channel mode byte |
| mask_i | input | NCH | Mask bits of all channels |
| cur_addr_i | input | AW | Channel current address |
| cur_cnt_i | input | CW | Channel current count |
| base_addr_i | input | AW | Channel base address |
| base_cnt_i | input | CW | Channel base count |
| busy_o | output | 1 | Elements still being issued |
| done_o | output | 1 | Result valid pulse |
| moved_o | output | CW | Elements moved by the request |
| wb_en_o | output | 1 | Write-back of current registers valid |
| wb_chan_o | output | CHW | Channel to write back |
| wb_addr_o | output | AW | New current address |
| wb_cnt_o | output | CW | New current count |
| tc_set_o | output | NCH | Terminal-count status set pulse |
| req_clr_o | output | NCH | Request status clear pulse |
| mem_stb_o | output | 1 | Memory element strobe |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory element address |

## Verification
Fault in the element pointer: shows on mem_addr_o at the next strobe. Fault in the remaining-element counter: busy_o ends early or late, so the error is visible within the moved count plus one cycle. Fault in the qualification or min/subtract path: every error lands in the single done cycle, as a wrong moved_o, wb_cnt_o, wb_addr_o or status pulse. The sweep therefore compares every field on that cycle and every strobe after it, with wrapping addresses in both directions.

// File: rtl/dma_se_pkg.sv
package dma_se_pkg;
  typedef enum logic [1:0] {
    OP_DEMAND  = 2'b00,
    OP_SINGLE  = 2'b01,
    OP_BLOCK   = 2'b10,
    OP_CASCADE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_WRITE  = 2'b01,
    XF_READ   = 2'b10,
    XF_BAD    = 2'b11
  } xfer_e;

  typedef struct packed {
    op_e        op;
    logic       dec;
    logic       autoinit;
    xfer_e      xfer;
    logic [1:0] sel;
  } mode_t;
endpackage

// File: rtl/dma_se_qualify.sv
module dma_se_qualify
  import dma_se_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  mode_t            mode_i,
  input  logic [NCH-1:0]   mask_i,
  input  logic [CHW-1:0]   chan_i,
  output logic             go_o
);
  logic masked;
  assign masked = mask_i[chan_i];
  assign go_o   = !masked && (mode_i.op == OP_SINGLE) && (mode_i.xfer != XF_BAD);
endmodule

// File: rtl/dma_se_calc.sv
module dma_se_calc #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            go_i,
  input  logic [CHW-1:0]  chan_i,
  input  logic            dec_i,
  input  logic            autoinit_i,
  input  logic [CW-1:0]   len_i,
  input  logic [AW-1:0]   cur_addr_i,
  input  logic [CW-1:0]   cur_cnt_i,
  input  logic [AW-1:0]   base_addr_i,
  input  logic [CW-1:0]   base_cnt_i,
  output logic [CW-1:0]   moved_o,
  output logic [AW-1:0]   nxt_addr_o,
  output logic [CW-1:0]   nxt_cnt_o,
  output logic [NCH-1:0]  tc_o
);
  logic [CW-1:0] take;
  logic [CW-1:0] left;
  logic [AW-1:0] step;
  logic [AW-1:0] moved_addr;
  logic          at_end;

  assign take       = (len_i < cur_cnt_i) ? len_i : cur_cnt_i;
  assign moved_o    = go_i ? take : '0;
  assign left       = cur_cnt_i - moved_o;
  assign step       = AW'(moved_o);
  assign moved_addr = dec_i ? (cur_addr_i - step) : (cur_addr_i + step);
  assign at_end     = go_i && (left == '0);

  always_comb begin
    if (at_end && autoinit_i) begin
      nxt_addr_o = base_addr_i;
      nxt_cnt_o  = base_cnt_i;
    end else begin
      nxt_addr_o = moved_addr;
      nxt_cnt_o  = left;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_tc
    assign tc_o[g] = at_end && (chan_i == CHW'(g));
  end
endmodule

// File: rtl/dma_se_issue.sv
module dma_se_issue
  import dma_se_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           dec_i,
  input  xfer_e          xfer_i,
  output logic           busy_o,
  output logic           stb_o,
  output logic           we_o,
  output logic [AW-1:0]  addr_o
);
  logic [CW-1:0] left_q;
  logic [AW-1:0] ptr_q;
  logic          dec_q;
  xfer_e         xf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      ptr_q  <= '0;
      dec_q  <= 1'b0;
      xf_q   <= XF_VERIFY;
    end else if (load_i) begin
      left_q <= cnt_i;
      ptr_q  <= addr_i;
      dec_q  <= dec_i;
      xf_q   <= xfer_i;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      ptr_q  <= dec_q ? ptr_q - 1'b1 : ptr_q + 1'b1;
    end
  end

  assign busy_o = (left_q != '0);
  assign stb_o  = busy_o && (xf_q != XF_VERIFY);
  assign we_o   = stb_o && (xf_q == XF_WRITE);
  assign addr_o = ptr_q;

  // R6: consecutive elements one step apart in the latched direction
  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (addr_o == ($past(dec_q) ? $past(ptr_q) - 1'b1 : $past(ptr_q) + 1'b1)));
endmodule

// File: rtl/dma_single_engine.sv
module dma_single_engine
  import dma_se_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [CHW-1:0]  chan_i,
  input  logic [CW-1:0]   len_i,
  input  logic [7:0]      mode_i,
  input  logic [NCH-1:0]  mask_i,
  input  logic [AW-1:0]   cur_addr_i,
  input  logic [CW-1:0]   cur_cnt_i,
  input  logic [AW-1:0]   base_addr_i,
  input  logic [CW-1:0]   base_cnt_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [CW-1:0]   moved_o,
  output logic            wb_en_o,
  output logic [CHW-1:0]  wb_chan_o,
  output logic [AW-1:0]   wb_addr_o,
  output logic [CW-1:0]   wb_cnt_o,
  output logic [NCH-1:0]  tc_set_o,
  output logic [NCH-1:0]  req_clr_o,
  output logic            mem_stb_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o
);
  mode_t          mode;
  logic           go;
  logic           accept;
  logic [CW-1:0]  moved_c;
  logic [AW-1:0]  nxt_addr_c;
  logic [CW-1:0]  nxt_cnt_c;
  logic [NCH-1:0] tc_c;

  logic           done_q;
  logic [CW-1:0]  moved_q;
  logic           wb_en_q;
  logic [CHW-1:0] wb_chan_q;
  logic [AW-1:0]  wb_addr_q;
  logic [CW-1:0]  wb_cnt_q;
  logic [NCH-1:0] tc_q;

  assign mode   = mode_t'(mode_i);
  assign accept = req_i && !busy_o;

  dma_se_qualify #(.NCH(NCH)) u_qualify (
    .mode_i (mode),
    .mask_i (mask_i),
    .chan_i (chan_i),
    .go_o   (go)
  );

  dma_se_calc #(.NCH(NCH), .AW(AW), .CW(CW)) u_calc (
    .go_i        (go),
    .chan_i      (chan_i),
    .dec_i       (mode.dec),
    .autoinit_i  (mode.autoinit),
    .len_i       (len_i),
    .cur_addr_i  (cur_addr_i),
    .cur_cnt_i   (cur_cnt_i),
    .base_addr_i (base_addr_i),
    .base_cnt_i  (base_cnt_i),
    .moved_o     (moved_c),
    .nxt_addr_o  (nxt_addr_c),
    .nxt_cnt_o   (nxt_cnt_c),
    .tc_o        (tc_c)
  );

  dma_se_issue #(.AW(AW), .CW(CW)) u_issue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept && go),
    .cnt_i  (moved_c),
    .addr_i (cur_addr_i),
    .dec_i  (mode.dec),
    .xfer_i (mode.xfer),
    .busy_o (busy_o),
    .stb_o  (mem_stb_o),
    .we_o   (mem_we_o),
    .addr_o (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      moved_q   <= '0;
      wb_en_q   <= 1'b0;
      wb_chan_q <= '0;
      wb_addr_q <= '0;
      wb_cnt_q  <= '0;
      tc_q      <= '0;
    end else if (accept) begin
      done_q    <= 1'b1;
      moved_q   <= moved_c;
      wb_en_q   <= go;
      wb_chan_q <= chan_i;
      wb_addr_q <= nxt_addr_c;
      wb_cnt_q  <= nxt_cnt_c;
      tc_q      <= tc_c;
    end else begin
      done_q    <= 1'b0;
      wb_en_q   <= 1'b0;
      tc_q      <= '0;
    end
  end

  assign done_o    = done_q;
  assign moved_o   = moved_q;
  assign wb_en_o   = wb_en_q;
  assign wb_chan_o = wb_chan_q;
  assign wb_addr_o = wb_addr_q;
  assign wb_cnt_o  = wb_cnt_q;
  assign tc_set_o  = tc_q;
  assign req_clr_o = tc_q;

  a_r1_masked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mask_i[chan_i]) |=> (moved_o == '0 && !wb_en_o && !busy_o && tc_set_o == '0));

  a_r4_moved_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (moved_o <= $past(len_i) && moved_o <= $past(cur_cnt_i)));

  a_r7_tc_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tc_set_o));

  a_r7_tc_with_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_set_o != '0) |-> (done_o && wb_en_o));

  a_r9_no_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !done_o);
endmodule

// File: tb/dma_single_engine_tb.sv
module dma_single_engine_tb;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 16;
  localparam int CHW = 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_i = 1'b0;
  logic [CHW-1:0]  chan_i = '0;
  logic [CW-1:0]   len_i = '0;
  logic [7:0]      mode_i = '0;
  logic [NCH-1:0]  mask_i = '0;
  logic [AW-1:0]   cur_addr_i = '0;
  logic [CW-1:0]   cur_cnt_i = '0;
  logic [AW-1:0]   base_addr_i = '0;
  logic [CW-1:0]   base_cnt_i = '0;
  logic            busy_o, done_o, wb_en_o, mem_stb_o, mem_we_o;
  logic [CW-1:0]   moved_o, wb_cnt_o;
  logic [CHW-1:0]  wb_chan_o;
  logic [AW-1:0]   wb_addr_o, mem_addr_o;
  logic [NCH-1:0]  tc_set_o, req_clr_o;

  int nvec = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  dma_single_engine #(.NCH(NCH), .AW(AW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .chan_i(chan_i), .len_i(len_i),
    .mode_i(mode_i), .mask_i(mask_i), .cur_addr_i(cur_addr_i), .cur_cnt_i(cur_cnt_i),
    .base_addr_i(base_addr_i), .base_cnt_i(base_cnt_i), .busy_o(busy_o), .done_o(done_o),
    .moved_o(moved_o), .wb_en_o(wb_en_o), .wb_chan_o(wb_chan_o), .wb_addr_o(wb_addr_o),
    .wb_cnt_o(wb_cnt_o), .tc_set_o(tc_set_o), .req_clr_o(req_clr_o),
    .mem_stb_o(mem_stb_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int ch, input int len, input logic [7:0] mode, input logic mbit,
                     input logic [AW-1:0] ca, input int cnt,
                     input logic [AW-1:0] ba, input int bc);
    logic [1:0] op, typ;
    logic dec, ai, valid, tc;
    int mv, ncnt;
    logic [AW-1:0] eaddr, ecnt, ptr;
    logic [NCH-1:0] etc;
    string rtag;
    op  = mode[7:6];
    dec = mode[5];
    ai  = mode[4];
    typ = mode[3:2];
    valid = !mbit && op == 2'b01 && typ != 2'b11;
    rtag = mbit ? "R1" : (op != 2'b01) ? "R2" : (typ == 2'b11) ? "R3" : "R4";
    mv   = valid ? ((len < cnt) ? len : cnt) : 0;
    ncnt = cnt - mv;
    tc   = valid && ncnt == 0;
    eaddr = dec ? ca - AW'(mv) : ca + AW'(mv);
    ecnt  = CW'(ncnt);
    if (tc && ai) begin eaddr = ba; ecnt = CW'(bc); end
    etc = tc ? NCH'(1) << ch : '0;

    @(negedge clk);
    chan_i = CHW'(ch); len_i = CW'(len); mode_i = mode;
    mask_i = mbit ? NCH'(1) << ch : ~(NCH'(1) << ch);
    cur_addr_i = ca; cur_cnt_i = CW'(cnt); base_addr_i = ba; base_cnt_i = CW'(bc);
    req_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    chk(done_o == 1'b1, "R9 done", done_o, 1);
    chk(moved_o == CW'(mv), {rtag, " moved"}, moved_o, mv);
    chk(wb_en_o == valid, {rtag, " wb_en"}, wb_en_o, valid);
    if (valid) begin
      chk(wb_chan_o == CHW'(ch), "R4 wb_chan", wb_chan_o, ch);
      chk(wb_cnt_o == ecnt, ai ? "R8 wb_cnt" : "R4 wb_cnt", wb_cnt_o, ecnt);
      chk(wb_addr_o == eaddr, ai ? "R8 wb_addr" : "R5 wb_addr", wb_addr_o, eaddr);
    end
    chk(tc_set_o == etc, "R7 tc_set", tc_set_o, etc);
    chk(req_clr_o == etc, "R7 req_clr", req_clr_o, etc);
    chk(busy_o == (mv != 0), "R6 busy", busy_o, mv != 0);
    ptr = ca;
    for (int e = 0; e < mv; e++) begin
      if (e > 0) @(negedge clk);
      chk(busy_o == 1'b1, "R6 busy run", busy_o, 1);
      chk(mem_stb_o == (typ != 2'b00), "R3 strobe", mem_stb_o, typ != 2'b00);
      if (typ != 2'b00) begin
        chk(mem_we_o == (typ == 2'b01), "R3 we", mem_we_o, typ == 2'b01);
        chk(mem_addr_o == ptr, "R6 addr", mem_addr_o, ptr);
      end
      ptr = dec ? ptr - 1'b1 : ptr + 1'b1;
    end
    @(negedge clk);
    chk(busy_o == 1'b0, "R6 busy end", busy_o, 0);
    chk(mem_stb_o == 1'b0, "R6 strobe end", mem_stb_o, 0);
    chk(done_o == 1'b0, "R9 done pulse", done_o, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done_o == 0 && busy_o == 0 && mem_stb_o == 0 && mem_we_o == 0, "R10 ctl", done_o, 0);
    chk(wb_en_o == 0 && tc_set_o == 0 && req_clr_o == 0 && moved_o == 0, "R10 res", moved_o, 0);
    rst_ni = 1'b1;

    // exhaustive over mode fields, mask, and small length/count pairs
    for (int op = 0; op < 4; op++)
      for (int ty = 0; ty < 4; ty++)
        for (int dr = 0; dr < 2; dr++)
          for (int ai = 0; ai < 2; ai++)
            for (int mk = 0; mk < 2; mk++)
              for (int li = 0; li < 3; li++)
                for (int ci = 0; ci < 3; ci++) begin
                  int ch;
                  logic [7:0] md;
                  ch = (op + ty + li + ci) % NCH;
                  md = {op[1:0], dr[0], ai[0], ty[1:0], 2'(ch)};
                  run(ch, (li == 2) ? 3 : li, md, mk[0],
                      dr[0] ? 16'h0001 : 16'hFFFE, (ci == 0) ? 0 : ci + 1,
                      16'h1230 + 16'(ch), 7);
                end

    // R9: requests while busy are ignored
    @(negedge clk);
    chan_i = 2; len_i = 3; mode_i = 8'b0100_0110; mask_i = 4'b1011;
    cur_addr_i = 16'h0040; cur_cnt_i = 5; base_addr_i = 0; base_cnt_i = 0;
    req_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(done_o == 1 && moved_o == 3, "R9 busy accept", moved_o, 3);
    chan_i = 1; len_i = 1; mode_i = 8'b0100_1001; cur_addr_i = 16'h9000; mask_i = 4'b0000;
    @(negedge clk);
    chk(done_o == 0, "R9 ignored 1", done_o, 0);
    chk(mem_addr_o == 16'h0041 && mem_we_o == 1, "R9 run 1", mem_addr_o, 16'h0041);
    @(negedge clk);
    req_i = 1'b0;
    chk(done_o == 0, "R9 ignored 2", done_o, 0);
    chk(mem_addr_o == 16'h0042 && mem_we_o == 1, "R9 run 2", mem_addr_o, 16'h0042);
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && mem_stb_o == 0, "R9 after busy", busy_o, 0);

    finish_run();
  end
endmodule